// File: doc/BRIEF.md
# Keypad-programmed square-wave generator

This block drives a one-bit square wave toward a loudspeaker. Its pitch comes from a decimal key code of a ten-key keypad. A key value `x` from 1 to 9 selects a full output period of `x` milliseconds. A free-running divider, clocked by the system clock, counts out half periods and flips the output at the end of each one. With a 100 MHz clock, one key unit is 50,000 clock cycles of half period, so the full period works out to `x` ms.

Each strobed key is handled as an event.

- **Non-zero key (1 to 9):** it loads a new half-period length and restarts the half-period count from that cycle.
- **Key 0:** it halts the divider. The output stays at whatever level it had until a later non-zero key restarts toggling from that level.
- **Codes 10 to 15:** they are discarded and change nothing.

Reset is asynchronous and active low. Its release is expected to be synchronous to the clock. Reset leaves the output low and the divider halted.

Top module: `keytone_gen`

## Requirements
- R1: While reset is asserted and after it is released, `wave_o` is 0 and does not change until a key in the range 1 to 9 is accepted.
- R2: A key `x` in 1..9 is accepted on the clock edge where `key_vld_i` is 1. `wave_o` first flips exactly `x * UNIT_CYCLES` clock edges after that accepting edge.
- R3: While running with key `x`, successive flips of `wave_o` are exactly `x * UNIT_CYCLES` edges apart, which gives a full period of `2 * x * UNIT_CYCLES` cycles.
- R4: An accepted key 0 stops toggling from the accepting edge on, including when that edge is a terminal-count edge. `wave_o` keeps its present level for as long as no non-zero key arrives.
- R5: A key 1..9 accepted while halted resumes toggling from the held level. The first flip comes `x * UNIT_CYCLES` edges after acceptance.
- R6: Key codes 10 to 15 are ignored. A running divider keeps its phase and period, and a halted one stays halted at the same level.
- R7: A key 1..9 accepted while running discards the partly counted half period and starts timing afresh from the accepting edge. If that edge coincides with the end of a half period, `wave_o` does not flip on it.
- R8: With `key_vld_i` at 0, the value on `key_i` has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| key_vld_i | input | 1 | Key strobe; `key_i` is taken on the edge where this is 1 |
| key_i | input | KEY_W | Key code; 0 halts, 1..9 set the period in ms, 10..15 are ignored |
| wave_o | output | 1 | Square-wave output |

## Verification
The hardest case to reach from the ports is a key event landing on the very clock edge where a half period ends. That edge is where a flip and a reload or halt compete. The stimulus reaches it by measuring the edge on which the output last flipped and then counting cycles from there, so that the strobe falls exactly on the terminal edge. This is done once with a new period and once with key 0. Random key sequences from a fixed seed also drop ignored codes into a running divider right after a measured flip. This checks that the next flip still arrives on its original schedule.

// File: rtl/keytone_pkg.sv
package keytone_pkg;

  // Action requested by one key event.
  typedef enum logic [1:0] {
    CMD_NONE = 2'd0,
    CMD_LOAD = 2'd1,
    CMD_STOP = 2'd2
  } key_cmd_e;

endpackage

// File: rtl/keytone_decode.sv
module keytone_decode
  import keytone_pkg::*;
#(
  parameter int KEY_W       = 4,
  parameter int KEY_MAX     = 9,
  parameter int UNIT_CYCLES = 50000,
  parameter int LIM_W       = 19
) (
  input  logic             key_vld_i,
  input  logic [KEY_W-1:0] key_i,
  output key_cmd_e         cmd_o,
  output logic [LIM_W-1:0] lim_o
);

  logic key_zero;
  logic key_in_range;

  always_comb begin
    key_zero     = (key_i == '0);
    key_in_range = (key_i <= KEY_W'(KEY_MAX));
    // Half-period length in clock cycles for the presented key.
    lim_o        = LIM_W'(key_i) * LIM_W'(UNIT_CYCLES);
    if (!key_vld_i) begin
      cmd_o = CMD_NONE;
    end else if (key_zero) begin
      cmd_o = CMD_STOP;
    end else if (key_in_range) begin
      cmd_o = CMD_LOAD;
    end else begin
      cmd_o = CMD_NONE;
    end
  end

endmodule

// File: rtl/keytone_div.sv
module keytone_div
  import keytone_pkg::*;
#(
  parameter int LIM_W = 19
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  key_cmd_e         cmd_i,
  input  logic [LIM_W-1:0] lim_i,
  output logic             run_o,
  output logic [LIM_W-1:0] cnt_o,
  output logic [LIM_W-1:0] lim_o,
  output logic             tick_o
);

  logic             run_q, run_d;
  logic [LIM_W-1:0] cnt_q, cnt_d;
  logic [LIM_W-1:0] lim_q, lim_d;
  logic             at_end;
  logic             upd_en;

  always_comb begin
    at_end = run_q && (cnt_q == lim_q - LIM_W'(1));
    // A key event on the terminal edge wins over the flip.
    tick_o = at_end && (cmd_i == CMD_NONE);
    run_d  = run_q;
    cnt_d  = cnt_q;
    lim_d  = lim_q;
    case (cmd_i)
      CMD_LOAD: begin
        run_d = 1'b1;
        cnt_d = '0;
        lim_d = lim_i;
      end
      CMD_STOP: begin
        run_d = 1'b0;
        cnt_d = '0;
      end
      default: begin
        if (run_q) begin
          cnt_d = at_end ? '0 : cnt_q + LIM_W'(1);
        end
      end
    endcase
    upd_en = run_q || (cmd_i != CMD_NONE);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      cnt_q <= '0;
      lim_q <= '0;
    end else if (upd_en) begin
      run_q <= run_d;
      cnt_q <= cnt_d;
      lim_q <= lim_d;
    end
  end

  assign run_o = run_q;
  assign cnt_o = cnt_q;
  assign lim_o = lim_q;

endmodule

// File: rtl/keytone_wave.sv
module keytone_wave (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  output logic wave_o
);

  logic wave_q, wave_d;

  always_comb begin
    wave_d = ~wave_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wave_q <= 1'b0;
    end else if (tick_i) begin
      wave_q <= wave_d;
    end
  end

  assign wave_o = wave_q;

endmodule

// File: rtl/keytone_gen.sv
module keytone_gen
  import keytone_pkg::*;
#(
  parameter int KEY_W       = 4,
  parameter int KEY_MAX     = 9,
  parameter int UNIT_CYCLES = 50000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             key_vld_i,
  input  logic [KEY_W-1:0] key_i,
  output logic             wave_o
);

  localparam int LIM_W = $clog2(KEY_MAX * UNIT_CYCLES + 1);

  key_cmd_e         key_cmd;
  logic [LIM_W-1:0] lim_new;
  logic             run_q;
  logic [LIM_W-1:0] cnt_q;
  logic [LIM_W-1:0] lim_q;
  logic             half_tick;

  keytone_decode #(
    .KEY_W      (KEY_W),
    .KEY_MAX    (KEY_MAX),
    .UNIT_CYCLES(UNIT_CYCLES),
    .LIM_W      (LIM_W)
  ) u_decode (
    .key_vld_i(key_vld_i),
    .key_i    (key_i),
    .cmd_o    (key_cmd),
    .lim_o    (lim_new)
  );

  keytone_div #(
    .LIM_W(LIM_W)
  ) u_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cmd_i (key_cmd),
    .lim_i (lim_new),
    .run_o (run_q),
    .cnt_o (cnt_q),
    .lim_o (lim_q),
    .tick_o(half_tick)
  );

  keytone_wave u_wave (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(half_tick),
    .wave_o(wave_o)
  );

endmodule

// File: rtl/keytone_chk.sv
module keytone_chk #(
  parameter int KEY_W   = 4,
  parameter int KEY_MAX = 9,
  parameter int LIM_W   = 19
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             key_vld_i,
  input logic [KEY_W-1:0] key_i,
  input logic             wave_o,
  input logic             run_q,
  input logic [LIM_W-1:0] cnt_q,
  input logic [LIM_W-1:0] lim_q
);

  // R1
  wave_moves_only_running_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(wave_o) |-> $past(run_q));

  // R2
  cnt_within_limit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> (cnt_q < lim_q));

  // R3
  flip_at_terminal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && !key_vld_i && cnt_q == lim_q - LIM_W'(1)) |=> (wave_o != $past(wave_o)));

  // R4
  zero_key_halts_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key_vld_i && key_i == '0) |=> (!run_q && $stable(wave_o)));

  // R5
  load_starts_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key_vld_i && key_i != '0 && key_i <= KEY_W'(KEY_MAX)) |=> run_q);

  // R6
  bad_key_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key_vld_i && key_i > KEY_W'(KEY_MAX) && !run_q) |=> (!run_q && $stable(wave_o)));

  // R7
  load_restarts_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key_vld_i && key_i != '0 && key_i <= KEY_W'(KEY_MAX)) |=> (cnt_q == '0 && $stable(wave_o)));

  // R8
  no_strobe_no_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!key_vld_i && !run_q) |=> (!run_q && $stable(wave_o)));

endmodule

bind keytone_gen keytone_chk #(
  .KEY_W  (KEY_W),
  .KEY_MAX(KEY_MAX),
  .LIM_W  (LIM_W)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .key_vld_i(key_vld_i),
  .key_i    (key_i),
  .wave_o   (wave_o),
  .run_q    (run_q),
  .cnt_q    (cnt_q),
  .lim_q    (lim_q)
);

// File: tb/tb_keytone_gen.sv
`timescale 1ns/1ps
module tb_keytone_gen;

  localparam int U    = 8;
  localparam int KMAX = 9;
  localparam int MAXW = 2 * KMAX * U + 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       key_vld;
  logic [3:0] key;
  logic       wave;

  int vecs  = 0;
  int fails = 0;
  int cyc   = 0;
  bit done  = 0;

  bit m_run;
  int m_half;
  logic m_lvl;

  keytone_gen #(.KEY_W(4), .KEY_MAX(KMAX), .UNIT_CYCLES(U)) dut (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .key_vld_i(key_vld),
    .key_i    (key),
    .wave_o   (wave)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int half_of(int k);
    return k * U;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    vecs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic press(int k);
    @(negedge clk);
    key_vld = 1'b1;
    key     = k[3:0];
    @(posedge clk);
    #1;
    key_vld = 1'b0;
  endtask

  // Cycles from the current edge until wave next changes; -1 on timeout.
  task automatic wait_toggle(output int n);
    logic l0;
    l0 = wave;
    n  = 0;
    forever begin
      @(posedge clk);
      #1;
      n++;
      if (wave !== l0) return;
      if (n > MAXW) begin
        n = -1;
        return;
      end
    end
  endtask

  task automatic hold_check(int cycles, logic lvl, string req);
    bit moved;
    moved = 0;
    for (int i = 0; i < cycles; i++) begin
      @(posedge clk);
      #1;
      if (wave !== lvl) moved = 1;
    end
    chk(!moved && wave === lvl, req, int'(wave), int'(lvl));
  endtask

  task automatic load_and_measure(int k, string req_first);
    int n;
    press(k);
    wait_toggle(n);
    chk(n == half_of(k), req_first, n, half_of(k));
    m_lvl = ~m_lvl;
    chk(wave === m_lvl, req_first, int'(wave), int'(m_lvl));
    wait_toggle(n);
    chk(n == half_of(k), "R3", n, half_of(k));
    m_lvl = ~m_lvl;
    m_run = 1;
    m_half = half_of(k);
  endtask

  initial begin
    wait (cyc >= 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end

  initial begin
    int n;
    int k;
    void'($urandom(32'd20110712));
    rst_n   = 1'b0;
    key_vld = 1'b0;
    key     = 4'd0;
    m_run   = 0;
    m_half  = 0;
    m_lvl   = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk(wave === 1'b0, "R1", int'(wave), 0);
    @(negedge clk);
    rst_n = 1'b1;
    hold_check(100, 1'b0, "R1");

    // R8: key present without strobe
    @(negedge clk);
    key = 4'd3;
    hold_check(100, 1'b0, "R8");

    // R2 / R3 directed
    load_and_measure(1, "R2");
    load_and_measure(9, "R2");

    // R7: restart mid half period
    repeat (20) @(posedge clk);
    press(2);
    wait_toggle(n);
    chk(n == half_of(2), "R7", n, half_of(2));
    m_lvl = ~m_lvl;

    // R7: new key on the terminal edge (half = 16, E0 = T + 16)
    repeat (15) @(posedge clk);
    press(3);
    chk(wave === m_lvl, "R7", int'(wave), int'(m_lvl));
    wait_toggle(n);
    chk(n == half_of(3), "R7", n, half_of(3));
    m_lvl = ~m_lvl;

    // R4: halt, then ignored code while halted, then resume (R5)
    press(0);
    hold_check(200, m_lvl, "R4");
    press(12);
    hold_check(100, m_lvl, "R6");
    press(4);
    wait_toggle(n);
    chk(n == half_of(4), "R5", n, half_of(4));
    m_lvl = ~m_lvl;

    // R6: ignored code while running keeps the phase
    press(15);
    wait_toggle(n);
    chk(n == half_of(4) - 1, "R6", n, half_of(4) - 1);
    m_lvl = ~m_lvl;
    wait_toggle(n);
    chk(n == half_of(4), "R6", n, half_of(4));
    m_lvl = ~m_lvl;

    // R4: halt on the terminal edge (half = 32, E0 = T + 32)
    repeat (31) @(posedge clk);
    press(0);
    chk(wave === m_lvl, "R4", int'(wave), int'(m_lvl));
    hold_check(150, m_lvl, "R4");
    m_run = 0;

    // Random key sequence
    for (int it = 0; it < 40; it++) begin
      k = int'($urandom_range(0, 15));
      if (k >= 1 && k <= KMAX) begin
        load_and_measure(k, m_run ? "R7" : "R5");
      end else if (k == 0) begin
        press(0);
        hold_check(2 * KMAX * U + 4, m_lvl, "R4");
        m_run = 0;
      end else if (m_run) begin
        press(k);
        wait_toggle(n);
        chk(n == m_half - 1, "R6", n, m_half - 1);
        m_lvl = ~m_lvl;
      end else begin
        press(k);
        hold_check(2 * KMAX * U + 4, m_lvl, "R6");
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

endmodule